// File: doc/BRIEF.md
# Chipset control register bank

This block is the 32-bit control and status register file of a system chipset. A processor reaches it through a plain synchronous bus. Each bus cycle carries an address, a write enable, a read enable, a two-bit access size and write data. The bank keeps the global configuration word, the DMA translation window, the I/O cache tag, mask and window words, a row of remote-speed words, a grid of per-channel DMA words and a few miscellaneous words. It only stores values. No DMA engine, cache or timer acts on them.

Byte and halfword accesses are folded onto the containing word. A narrow write replaces only its own lanes, and the other lanes keep the value that a read of that word would return in the same cycle. A narrow read returns the addressed lanes, zero-extended. Some words can only be read and some can only be written. The cache byte-mask word gathers writes by OR and empties itself once it has been read back as all ones.

Top module: `chipset_ctl_regs`

## Requirements
- R1: With `rst` high at a clock edge, every word returns to its reset value. Configuration (offset 0x000) holds 0x104. Offset 0x210 holds 0x18186. Offsets 0x220 and 0x238 hold 7. Every remote-speed word holds 7. All other words and `bus_rdata` hold 0.
- R2: Only address bits [13:0] take part in decoding, and bits [1:0] never select a word. Remote-speed word k (k = 0..14) lies at 0x070 + 8·k. DMA channel c (0..7), word r (0..3) lies at 0x100 + 32·c + 8·r. Inside these two windows an offset with bit 2 set is unmapped.
- R3: A word write (`bus_size` = 2) to a read-write word takes effect at the edge where `bus_we` is high. A read is registered, so `bus_rdata` shows the word after the edge at which `bus_re` was high.
- R4: A byte write (`bus_size` = 0) puts `bus_wdata[7:0]` into lane n = address[1:0], at bits [8n+7:8n], and keeps the other three lanes. A halfword write (`bus_size` = 1) puts `bus_wdata[15:0]` into bits [31:16] when address bit 1 is set and into bits [15:0] otherwise, and keeps the other half.
- R5: A byte read returns lane n = address[1:0] in bits [7:0]. A halfword read returns bits [31:16] when address bit 1 is set and bits [15:0] otherwise. The remaining upper bits of `bus_rdata` are zero in both cases.
- R6: Offsets 0x010, 0x038, 0x040, 0x208, 0x220 and 0x238 are read-only. Writes to them change nothing, and they always read as their reset values.
- R7: Offsets 0x048, 0x050, 0x060 and 0x228 are write-only. They accept writes and read as 0.
- R8: A write to the byte-mask word at 0x058 ORs the merged write value into its contents. No bit is ever cleared by a write.
- R9: A read of 0x058 that returns 0xFFFFFFFF as a whole word clears the byte-mask word to 0 after the read. A read of any other value leaves it unchanged.
- R10: A read of an unmapped offset returns 0. A write to an unmapped offset changes no word.
- R11: `bus_rdata` holds its value in cycles without a read. In a cycle with both enables high, the read returns the contents from before the write, the write is applied, and the byte-mask word is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte address; bits above 13 are ignored |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 or 3 word |
| bus_we | input | 1 | Write enable for this cycle |
| bus_re | input | 1 | Read enable for this cycle |
| bus_wdata | input | 32 | Write data, with narrow data in the low bits |
| bus_rdata | output | 32 | Registered read data |

## Verification
The stimulus is word writes and reads of read-write words, followed by byte and halfword writes to each lane and half of one word. Reading that word back at all three sizes separates a lane-placement error from a merge error. Read-only, write-only and unmapped offsets are written with recognisable data and then read back, and a neighbouring word is read as well, to show that nothing leaked. The byte-mask word is filled with partial masks, read twice before and twice after it becomes all ones, and hit with simultaneous read and write, which separates OR accumulation, clear-on-read and write priority. Edge offsets of the speed and DMA windows, aliased high address bits and bit-2 holes check the decode.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int OFF_W  = 14;
    localparam int IDX_W  = 6;
    localparam int WORD_STRIDE = 8;
    localparam int STRIDE_SH   = $clog2(WORD_STRIDE);

    typedef logic [DATA_W-1:0] word_t;

    // fixed word offsets (byte address, low two bits zero)
    localparam logic [OFF_W-1:0] OFF_CFG     = 14'h000;
    localparam logic [OFF_W-1:0] OFF_BADADDR = 14'h010;
    localparam logic [OFF_W-1:0] OFF_XLBASE  = 14'h018;
    localparam logic [OFF_W-1:0] OFF_XLLIMIT = 14'h020;
    localparam logic [OFF_W-1:0] OFF_RFAIL   = 14'h038;
    localparam logic [OFF_W-1:0] OFF_MFAIL   = 14'h040;
    localparam logic [OFF_W-1:0] OFF_PTAG    = 14'h048;
    localparam logic [OFF_W-1:0] OFF_LTAG    = 14'h050;
    localparam logic [OFF_W-1:0] OFF_BMASK   = 14'h058;
    localparam logic [OFF_W-1:0] OFF_BWIN    = 14'h060;
    localparam logic [OFF_W-1:0] OFF_SPEED   = 14'h070;
    localparam logic [OFF_W-1:0] OFF_DMA     = 14'h100;
    localparam logic [OFF_W-1:0] OFF_MISC_A  = 14'h208;
    localparam logic [OFF_W-1:0] OFF_MISC_B  = 14'h210;
    localparam logic [OFF_W-1:0] OFF_NVPROT  = 14'h220;
    localparam logic [OFF_W-1:0] OFF_RELOAD  = 14'h228;
    localparam logic [OFF_W-1:0] OFF_MISC_C  = 14'h238;

    // reset values
    localparam word_t RST_CFG    = 32'h0000_0104;
    localparam word_t RST_MISC_B = 32'h0001_8186;
    localparam word_t RST_NVPROT = 32'h0000_0007;
    localparam word_t RST_MISC_C = 32'h0000_0007;
    localparam word_t RST_SPEED  = 32'h0000_0007;
    localparam word_t RST_ZERO   = '0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [4:0] {
        K_NONE, K_CFG, K_BADADDR, K_XLBASE, K_XLLIMIT, K_RFAIL, K_MFAIL,
        K_PTAG, K_LTAG, K_BMASK, K_BWIN, K_SPEED, K_DMA,
        K_MISC_A, K_MISC_B, K_NVPROT, K_RELOAD, K_MISC_C
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
    } sel_t;

    // place narrow write data into the current word
    function automatic word_t merge_lanes(input word_t cur, input word_t data,
                                          input size_e size,
                                          input logic [LANE_W-1:0] lane);
        word_t r;
        r = cur;
        case (size)
            SZ_BYTE: r[{lane, 3'b000} +: 8] = data[7:0];
            SZ_HALF: begin
                if (lane[1]) r[31:16] = data[15:0];
                else         r[15:0]  = data[15:0];
            end
            default: r = data;
        endcase
        return r;
    endfunction

    // pick the addressed lanes out of a word, zero-extended
    function automatic word_t extract_lanes(input word_t w, input size_e size,
                                            input logic [LANE_W-1:0] lane);
        word_t r;
        case (size)
            SZ_BYTE: r = {24'b0, w[{lane, 3'b000} +: 8]};
            SZ_HALF: r = lane[1] ? {16'b0, w[31:16]} : {16'b0, w[15:0]};
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import crb_pkg::*;
#(
    parameter int N_SPEED       = 15,
    parameter int N_CHAN        = 8,
    parameter int REGS_PER_CHAN = 4
) (
    input  logic [OFF_W-3:0] word_off,
    output sel_t             sel
);
    localparam int SPEED_SPAN = N_SPEED * WORD_STRIDE;
    localparam int CHAN_SPAN  = REGS_PER_CHAN * WORD_STRIDE;
    localparam int DMA_SPAN   = N_CHAN * CHAN_SPAN;
    localparam logic [OFF_W-1:0] SPEED_END = OFF_W'(int'(OFF_SPEED) + SPEED_SPAN);
    localparam logic [OFF_W-1:0] DMA_END   = OFF_W'(int'(OFF_DMA) + DMA_SPAN);

    logic [OFF_W-1:0] w;
    logic [OFF_W-1:0] rel_spd;
    logic [OFF_W-1:0] rel_dma;

    always_comb begin
        w       = {word_off, 2'b00};
        rel_spd = w - OFF_SPEED;
        rel_dma = w - OFF_DMA;
        sel.kind = K_NONE;
        sel.idx  = '0;
        case (w)
            OFF_CFG:     sel.kind = K_CFG;
            OFF_BADADDR: sel.kind = K_BADADDR;
            OFF_XLBASE:  sel.kind = K_XLBASE;
            OFF_XLLIMIT: sel.kind = K_XLLIMIT;
            OFF_RFAIL:   sel.kind = K_RFAIL;
            OFF_MFAIL:   sel.kind = K_MFAIL;
            OFF_PTAG:    sel.kind = K_PTAG;
            OFF_LTAG:    sel.kind = K_LTAG;
            OFF_BMASK:   sel.kind = K_BMASK;
            OFF_BWIN:    sel.kind = K_BWIN;
            OFF_MISC_A:  sel.kind = K_MISC_A;
            OFF_MISC_B:  sel.kind = K_MISC_B;
            OFF_NVPROT:  sel.kind = K_NVPROT;
            OFF_RELOAD:  sel.kind = K_RELOAD;
            OFF_MISC_C:  sel.kind = K_MISC_C;
            default: begin
                if (w >= OFF_SPEED && w < SPEED_END &&
                    rel_spd[STRIDE_SH-1:0] == '0) begin
                    sel.kind = K_SPEED;
                    sel.idx  = IDX_W'(rel_spd >> STRIDE_SH);
                end else if (w >= OFF_DMA && w < DMA_END &&
                             rel_dma[STRIDE_SH-1:0] == '0) begin
                    sel.kind = K_DMA;
                    sel.idx  = IDX_W'(rel_dma >> STRIDE_SH);
                end
            end
        endcase
    end

    // R2: a decoded array index stays inside its array
    always_comb begin
        if (sel.kind == K_SPEED) a_speed_idx_r2: assert (int'(sel.idx) < N_SPEED);
        if (sel.kind == K_DMA)   a_dma_idx_r2:   assert (int'(sel.idx) < N_CHAN * REGS_PER_CHAN);
    end

endmodule

// File: rtl/crb_lanes.sv
module crb_lanes
    import crb_pkg::*;
(
    input  word_t             cur_word,
    input  word_t             wdata,
    input  size_e             size,
    input  logic [LANE_W-1:0] lane,
    output word_t             merged,
    output word_t             rd_view
);
    always_comb begin
        merged  = merge_lanes(cur_word, wdata, size, lane);
        rd_view = extract_lanes(cur_word, size, lane);
    end
endmodule

// File: rtl/crb_store.sv
module crb_store
    import crb_pkg::*;
#(
    parameter int N_SPEED       = 15,
    parameter int N_CHAN        = 8,
    parameter int REGS_PER_CHAN = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  sel_t  sel,
    input  word_t wr_word,
    output word_t cur_word
);
    localparam int DMA_ENTRIES = N_CHAN * REGS_PER_CHAN;

    word_t cfg_q, xlbase_q, xllimit_q, ptag_q, ltag_q, bmask_q, bwin_q;
    word_t misc_b_q, reload_q;
    word_t speed_q [N_SPEED];
    word_t dma_q   [DMA_ENTRIES];
    word_t spd_val, dma_val;
    logic  bmask_clear;

    function automatic logic hit(input sel_t s, input kind_e k, input logic en);
        return en && (s.kind == k);
    endfunction

    assign bmask_clear = rd_en && !wr_en && sel.kind == K_BMASK && bmask_q == '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= RST_CFG;
            xlbase_q  <= RST_ZERO;
            xllimit_q <= RST_ZERO;
            ptag_q    <= RST_ZERO;
            ltag_q    <= RST_ZERO;
            bmask_q   <= RST_ZERO;
            bwin_q    <= RST_ZERO;
            misc_b_q  <= RST_MISC_B;
            reload_q  <= RST_ZERO;
        end else begin
            if (hit(sel, K_CFG, wr_en))     cfg_q     <= wr_word;
            if (hit(sel, K_XLBASE, wr_en))  xlbase_q  <= wr_word;
            if (hit(sel, K_XLLIMIT, wr_en)) xllimit_q <= wr_word;
            if (hit(sel, K_PTAG, wr_en))    ptag_q    <= wr_word;
            if (hit(sel, K_LTAG, wr_en))    ltag_q    <= wr_word;
            if (hit(sel, K_BWIN, wr_en))    bwin_q    <= wr_word;
            if (hit(sel, K_MISC_B, wr_en))  misc_b_q  <= wr_word;
            if (hit(sel, K_RELOAD, wr_en))  reload_q  <= wr_word;
            if (hit(sel, K_BMASK, wr_en))   bmask_q   <= bmask_q | wr_word;
            else if (bmask_clear)           bmask_q   <= RST_ZERO;
        end
    end

    for (genvar i = 0; i < N_SPEED; i++) begin : g_speed
        always_ff @(posedge clk) begin
            if (rst) speed_q[i] <= RST_SPEED;
            else if (hit(sel, K_SPEED, wr_en) && sel.idx == IDX_W'(i)) speed_q[i] <= wr_word;
        end
    end

    for (genvar j = 0; j < DMA_ENTRIES; j++) begin : g_dma
        always_ff @(posedge clk) begin
            if (rst) dma_q[j] <= RST_ZERO;
            else if (hit(sel, K_DMA, wr_en) && sel.idx == IDX_W'(j)) dma_q[j] <= wr_word;
        end
    end

    always_comb begin
        spd_val = '0;
        for (int i = 0; i < N_SPEED; i++)
            if (sel.idx == IDX_W'(i)) spd_val = speed_q[i];
        dma_val = '0;
        for (int j = 0; j < DMA_ENTRIES; j++)
            if (sel.idx == IDX_W'(j)) dma_val = dma_q[j];
    end

    // readable view; write-only words show zero
    always_comb begin
        case (sel.kind)
            K_CFG:     cur_word = cfg_q;
            K_XLBASE:  cur_word = xlbase_q;
            K_XLLIMIT: cur_word = xllimit_q;
            K_BMASK:   cur_word = bmask_q;
            K_SPEED:   cur_word = spd_val;
            K_DMA:     cur_word = dma_val;
            K_MISC_B:  cur_word = misc_b_q;
            K_NVPROT:  cur_word = RST_NVPROT;
            K_MISC_C:  cur_word = RST_MISC_C;
            default:   cur_word = RST_ZERO;
        endcase
    end

    // write-only contents are kept for the rest of the chip but not read here
    logic unused_wo;
    assign unused_wo = ^{ptag_q, ltag_q, bwin_q, reload_q};

    // R8: a write never clears a mask bit
    p_bmask_or_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel.kind == K_BMASK) |=> ((bmask_q & $past(bmask_q)) == $past(bmask_q)));

    // R9: a lone read that sees all ones empties the mask
    p_bmask_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && sel.kind == K_BMASK && cur_word == '1) |=> (bmask_q == '0));

    // R3: configuration changes only when written
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel.kind == K_CFG) |=> $stable(cfg_q));

endmodule

// File: rtl/chipset_ctl_regs.sv
module chipset_ctl_regs
    import crb_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int N_SPEED       = 15,
    parameter int N_CHAN        = 8,
    parameter int REGS_PER_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    sel_t  sel;
    size_e size_c;
    word_t cur_word, merged, rd_view;
    word_t rdata_q;

    logic unused_hi;
    assign unused_hi = ^bus_addr[ADDR_W-1:OFF_W];
    assign size_c    = size_e'(bus_size);

    crb_decode #(
        .N_SPEED(N_SPEED), .N_CHAN(N_CHAN), .REGS_PER_CHAN(REGS_PER_CHAN)
    ) u_decode (
        .word_off (bus_addr[OFF_W-1:2]),
        .sel      (sel)
    );

    crb_store #(
        .N_SPEED(N_SPEED), .N_CHAN(N_CHAN), .REGS_PER_CHAN(REGS_PER_CHAN)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we),
        .rd_en    (bus_re),
        .sel      (sel),
        .wr_word  (merged),
        .cur_word (cur_word)
    );

    crb_lanes u_lanes (
        .cur_word (cur_word),
        .wdata    (bus_wdata),
        .size     (size_c),
        .lane     (bus_addr[LANE_W-1:0]),
        .merged   (merged),
        .rd_view  (rd_view)
    );

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= RST_ZERO;
        else if (bus_re) rdata_q <= rd_view;
    end

    assign bus_rdata = rdata_q;

    // R11: read data holds when nothing is read
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata));

    // R5: narrow reads are zero-extended
    p_byte_zext_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_size == 2'd0) |=> (bus_rdata[31:8] == '0));
    p_half_zext_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_size == 2'd1) |=> (bus_rdata[31:16] == '0));

    // R10: unmapped reads give zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_re && sel.kind == K_NONE) |=> (bus_rdata == '0));

    // R6: a read-only word always shows its reset value
    p_nvprot_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_size[1] && sel.kind == K_NVPROT) |=> (bus_rdata == RST_NVPROT));

endmodule

// File: tb/chipset_ctl_regs_test.sv
module chipset_ctl_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 53;

    typedef struct packed {
        logic        we;
        logic        re;
        logic [1:0]  sz;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // size codes: 0 byte, 1 halfword, 2 word
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,2'd2,16'h0018,32'hDEADBEEF,32'h0,8'd3},        // R3
        '{1'b0,1'b1,2'd2,16'h0018,32'h0,32'hDEADBEEF,8'd3},        // R3
        '{1'b0,1'b1,2'd2,16'h0000,32'h0,32'h00000104,8'd1},        // R1
        '{1'b0,1'b1,2'd2,16'h0210,32'h0,32'h00018186,8'd1},        // R1
        '{1'b0,1'b1,2'd2,16'h0220,32'h0,32'h00000007,8'd1},        // R1
        '{1'b0,1'b1,2'd2,16'h0078,32'h0,32'h00000007,8'd1},        // R1
        '{1'b0,1'b1,2'd2,16'h0238,32'h0,32'h00000007,8'd1},        // R1
        '{1'b0,1'b1,2'd2,16'h0208,32'h0,32'h00000000,8'd1},        // R1
        '{1'b1,1'b0,2'd0,16'h0019,32'h000000AA,32'h0,8'd4},        // R4
        '{1'b0,1'b1,2'd2,16'h0018,32'h0,32'hDEADAAEF,8'd4},        // R4
        '{1'b1,1'b0,2'd1,16'h001A,32'h00001234,32'h0,8'd4},        // R4
        '{1'b0,1'b1,2'd2,16'h0018,32'h0,32'h1234AAEF,8'd4},        // R4
        '{1'b0,1'b1,2'd0,16'h001B,32'h0,32'h00000012,8'd5},        // R5
        '{1'b0,1'b1,2'd0,16'h0018,32'h0,32'h000000EF,8'd5},        // R5
        '{1'b0,1'b1,2'd1,16'h0018,32'h0,32'h0000AAEF,8'd5},        // R5
        '{1'b0,1'b1,2'd1,16'h001A,32'h0,32'h00001234,8'd5},        // R5
        '{1'b1,1'b0,2'd2,16'h0220,32'hFFFFFFFF,32'h0,8'd6},        // R6
        '{1'b0,1'b1,2'd2,16'h0220,32'h0,32'h00000007,8'd6},        // R6
        '{1'b1,1'b0,2'd2,16'h0010,32'h00000005,32'h0,8'd6},        // R6
        '{1'b0,1'b1,2'd2,16'h0010,32'h0,32'h00000000,8'd6},        // R6
        '{1'b1,1'b0,2'd2,16'h0048,32'h11223344,32'h0,8'd7},        // R7
        '{1'b0,1'b1,2'd2,16'h0048,32'h0,32'h00000000,8'd7},        // R7
        '{1'b1,1'b0,2'd2,16'h0228,32'h00000055,32'h0,8'd7},        // R7
        '{1'b0,1'b1,2'd2,16'h0228,32'h0,32'h00000000,8'd7},        // R7
        '{1'b1,1'b0,2'd2,16'h0058,32'h0F0F0000,32'h0,8'd8},        // R8
        '{1'b1,1'b0,2'd2,16'h0058,32'h000F0F0F,32'h0,8'd8},        // R8
        '{1'b0,1'b1,2'd2,16'h0058,32'h0,32'h0F0F0F0F,8'd8},        // R8
        '{1'b0,1'b1,2'd2,16'h0058,32'h0,32'h0F0F0F0F,8'd9},        // R9 no clear
        '{1'b1,1'b0,2'd2,16'h0058,32'hF0F0F0F0,32'h0,8'd8},        // R8
        '{1'b0,1'b1,2'd2,16'h0058,32'h0,32'hFFFFFFFF,8'd9},        // R9
        '{1'b0,1'b1,2'd2,16'h0058,32'h0,32'h00000000,8'd9},        // R9 cleared
        '{1'b1,1'b0,2'd0,16'h005A,32'h00000081,32'h0,8'd8},        // R8
        '{1'b1,1'b0,2'd0,16'h0058,32'h00000003,32'h0,8'd8},        // R8
        '{1'b0,1'b1,2'd2,16'h0058,32'h0,32'h00810003,8'd8},        // R8
        '{1'b1,1'b0,2'd2,16'h0068,32'h99999999,32'h0,8'd10},       // R10
        '{1'b0,1'b1,2'd2,16'h0068,32'h0,32'h00000000,8'd10},       // R10
        '{1'b0,1'b1,2'd2,16'h0018,32'h0,32'h1234AAEF,8'd10},       // R10
        '{1'b0,1'b1,2'd2,16'h0104,32'h0,32'h00000000,8'd2},        // R2 hole
        '{1'b1,1'b0,2'd2,16'h0104,32'h00000001,32'h0,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h0100,32'h0,32'h00000000,8'd2},        // R2
        '{1'b1,1'b0,2'd2,16'hC128,32'hCAFE0001,32'h0,8'd2},        // R2 alias
        '{1'b0,1'b1,2'd2,16'h012B,32'h0,32'hCAFE0001,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h0108,32'h0,32'h00000000,8'd2},        // R2
        '{1'b1,1'b0,2'd2,16'h00E0,32'h00000003,32'h0,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h00E0,32'h0,32'h00000003,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h00E8,32'h0,32'h00000000,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h00D8,32'h0,32'h00000007,8'd2},        // R2
        '{1'b1,1'b0,2'd2,16'h01F8,32'h00000077,32'h0,8'd2},        // R2
        '{1'b0,1'b1,2'd2,16'h01F8,32'h0,32'h00000077,8'd2},        // R2
        '{1'b1,1'b0,2'd2,16'h0000,32'h0000ABCD,32'h0,8'd3},        // R3
        '{1'b0,1'b1,2'd2,16'h0000,32'h0,32'h0000ABCD,8'd3},        // R3
        '{1'b0,1'b1,2'd0,16'h0059,32'h0,32'h00000000,8'd5},        // R5
        '{1'b0,1'b1,2'd0,16'h005A,32'h0,32'h00000081,8'd5}         // R5
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_we, bus_re;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chipset_ctl_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; starts and ends at a falling edge, returns read data
    task automatic bus_op(input logic we, input logic re, input logic [1:0] sz,
                          input logic [15:0] a, input logic [31:0] wd,
                          output logic [31:0] got);
        bus_we = we; bus_re = re; bus_size = sz; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        got = bus_rdata;
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_we = 1'b0; bus_re = 1'b0; bus_size = 2'd2; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        do_reset();
        check("R1 rdata after reset", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].we, VECS[i].re, VECS[i].sz, VECS[i].addr, VECS[i].wd, got);
            if (VECS[i].re)
                check($sformatf("R%0d vector %0d", VECS[i].req, i), got, VECS[i].exp);
        end

        // R11: hold across idle cycles
        repeat (3) @(negedge clk);
        check("R11 rdata hold", bus_rdata, 32'h00000081);

        // R11: read and write in the same cycle
        bus_op(1'b1, 1'b0, 2'd2, 16'h0020, 32'h00001111, got);
        bus_op(1'b1, 1'b1, 2'd2, 16'h0020, 32'h00002222, got);
        check("R11 read before write", got, 32'h00001111);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0020, 32'h0, got);
        check("R11 write applied", got, 32'h00002222);

        // R11 and R9: simultaneous write suppresses clear
        bus_op(1'b1, 1'b0, 2'd2, 16'h0058, 32'hFFFFFFFF, got);
        bus_op(1'b1, 1'b1, 2'd2, 16'h0058, 32'h00000000, got);
        check("R11 mask read with write", got, 32'hFFFFFFFF);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0058, 32'h0, got);
        check("R11 mask not cleared", got, 32'hFFFFFFFF);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0058, 32'h0, got);
        check("R9 mask cleared", got, 32'h00000000);

        // R1: reset in the middle restores values
        do_reset();
        check("R1 rdata zero", bus_rdata, 32'h0);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0018, 32'h0, got);
        check("R1 base reset", got, 32'h0);
        bus_op(1'b0, 1'b1, 2'd2, 16'h00E0, 32'h0, got);
        check("R1 speed reset", got, 32'h7);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0000, 32'h0, got);
        check("R1 config reset", got, 32'h104);
        bus_op(1'b0, 1'b1, 2'd2, 16'h01F8, 32'h0, got);
        check("R1 dma reset", got, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule